// File: doc/BRIEF.md
# Video Line Timing and Interrupt Generator

This block keeps the scanline position of a video display controller. Each clock it takes the number of nanoseconds that elapsed and adds it into a remainder accumulator. Whenever that remainder covers one line period, the scanline counter steps forward and one period is taken out of the remainder. The line period and the number of lines per frame come from one of two display standards, picked by a configuration input.

The counter drives four single-cycle event outputs:
- a retrace pulse when the counter wraps to zero;
- two scanline interrupts whose line positions are loaded together from one 32-bit register write;
- a frame-present pulse.

A wrap arms a pending flag. The frame-present pulse fires when the counter later lands on a fixed line with the flag armed. It also fires at once when the display start address is rewritten while the flag is armed. A 32-bit frame counter counts the frame-present pulses.

Top module: `vlt_line_timer`

## Requirements
- R1: While reset is held and in the first cycle after its release, `line_idx` and `frame_count` read 0 and all four pulse outputs are low. Both interrupt positions reset to line 0.
- R2: Each clock the value of `ns_elapsed` is added to a remainder. When the sum reaches the line period, `line_idx` rises by one on that same clock edge and one period is subtracted. A value of 0 never advances the counter.
- R3: With `std_50hz` = 0 a frame has 525 lines of 31746 ns each. With `std_50hz` = 1 a frame has 625 lines of 32000 ns each.
- R4: An advance that would reach the frame's line count sets `line_idx` to 0, raises `retrace_pulse` for that one cycle and arms the pending flag.
- R5: Each advance that lands `line_idx` on interrupt position 1 raises `line1_irq` for one cycle. Each advance that lands on position 2 raises `line2_irq` for one cycle.
- R6: A cycle with `pos_wr_en` = 1 loads position 1 from `pos_wr_data[25:16]` and position 2 from `pos_wr_data[9:0]`. All other data bits are ignored.
- R7: An advance that lands on line 65 while the pending flag is armed raises `present_pulse` for one cycle and clears the flag. Landing on line 65 with the flag clear gives no pulse.
- R8: A cycle with `base_wr_en` = 1 while the flag is armed raises `present_pulse` on that edge and clears the flag. With the flag clear the strobe has no effect.
- R9: `frame_count` rises by exactly one on each `present_pulse` and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ns_elapsed | input | 8 | Nanoseconds elapsed in this clock |
| std_50hz | input | 1 | 1 selects 625-line/32000 ns, 0 selects 525-line/31746 ns |
| pos_wr_en | input | 1 | Write strobe for the interrupt-position register |
| pos_wr_data | input | 32 | Interrupt-position word (pos1 in 25:16, pos2 in 9:0) |
| base_wr_en | input | 1 | Strobe marking a write of the display start address |
| line_idx | output | 10 | Current scanline |
| retrace_pulse | output | 1 | One-cycle frame wrap pulse |
| line1_irq | output | 1 | One-cycle scanline interrupt 1 |
| line2_irq | output | 1 | One-cycle scanline interrupt 2 |
| present_pulse | output | 1 | One-cycle frame-present pulse |
| frame_count | output | 32 | Number of frame-present pulses since reset |

## Verification
A remainder error shows at `line_idx` as a drift in the cycle where each line begins. With the maximum increment that drift appears within one line period, roughly 125 clocks. A wrong line count or wrap compare first shows at the end of a frame, as a retrace pulse on the wrong cycle or a missing one. A pending flag left set or cleared by mistake only shows later: as a missing frame-present pulse at line 65, or as a stray pulse on a start-address write, with `frame_count` off by one from then on. The bench therefore runs full frames in both standards and places strobes both with the flag armed and with it clear.

// File: rtl/vlt_pkg.sv
package vlt_pkg;

    typedef struct packed {
        logic retrace;
        logic irq1;
        logic irq2;
        logic present;
    } vlt_events_t;

endpackage

// File: rtl/vlt_accum.sv
module vlt_accum #(
    parameter int NS_W  = 8,
    parameter int ACC_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NS_W-1:0]  ns_inc,
    input  logic [ACC_W-1:0] period,
    output logic             advance
);
    logic [ACC_W-1:0] rem_d, rem_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        sum     = rem_q + ACC_W'(ns_inc);
        advance = (sum >= period);
        rem_d   = advance ? (sum - period) : sum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end
endmodule

// File: rtl/vlt_posreg.sv
module vlt_posreg #(
    parameter int LINE_W = 10,
    parameter int DATA_W = 32,
    parameter int LSB_P1 = 16,
    parameter int LSB_P2 = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [1:0][LINE_W-1:0]      pos
);
    // index 1 holds position 1, index 0 holds position 2
    for (genvar g = 0; g < 2; g++) begin : g_field
        localparam int LSB = (g == 1) ? LSB_P1 : LSB_P2;
        logic [LINE_W-1:0] pos_d, pos_q;

        always_comb begin
            pos_d = pos_q;
            if (wr_en) pos_d = wr_data[LSB +: LINE_W];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) pos_q <= '0;
            else        pos_q <= pos_d;
        end

        assign pos[g] = pos_q;
    end
endmodule

// File: rtl/vlt_scan.sv
module vlt_scan
    import vlt_pkg::*;
#(
    parameter int LINE_W       = 10,
    parameter int FRAME_W      = 32,
    parameter int PRESENT_LINE = 65
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   advance,
    input  logic [LINE_W-1:0]      total,
    input  logic [1:0][LINE_W-1:0] pos,
    input  logic                   base_wr,
    output logic [LINE_W-1:0]      line,
    output vlt_events_t            events,
    output logic [FRAME_W-1:0]     frame_count
);
    localparam logic [LINE_W-1:0] PRES = LINE_W'(PRESENT_LINE);

    typedef struct packed {
        logic [LINE_W-1:0]  line;
        logic               pend;
        logic [FRAME_W-1:0] frame;
        vlt_events_t        ev;
    } scan_st_t;

    scan_st_t st_d, st_q;
    logic [LINE_W:0]   inc;
    logic              wrap;
    logic [LINE_W-1:0] cand;
    logic [1:0]        hit;

    always_comb begin
        inc  = {1'b0, st_q.line} + 1'b1;
        wrap = (inc >= {1'b0, total});
        cand = wrap ? '0 : inc[LINE_W-1:0];
    end

    for (genvar g = 0; g < 2; g++) begin : g_cmp
        assign hit[g] = (cand == pos[g]);
    end

    always_comb begin
        st_d    = st_q;
        st_d.ev = '0;
        if (advance) begin
            st_d.line    = cand;
            st_d.ev.irq1 = hit[1];
            st_d.ev.irq2 = hit[0];
            if (wrap) begin
                st_d.ev.retrace = 1'b1;
                st_d.pend       = 1'b1;
            end
            if (cand == PRES && st_d.pend) begin
                st_d.ev.present = 1'b1;
                st_d.pend       = 1'b0;
            end
        end
        if (base_wr && st_d.pend) begin
            st_d.ev.present = 1'b1;
            st_d.pend       = 1'b0;
        end
        if (st_d.ev.present) st_d.frame = st_q.frame + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line        = st_q.line;
    assign events      = st_q.ev;
    assign frame_count = st_q.frame;
endmodule

// File: rtl/vlt_line_timer.sv
module vlt_line_timer
    import vlt_pkg::*;
#(
    parameter int NS_W         = 8,
    parameter int LINE_W       = 10,
    parameter int FRAME_W      = 32,
    parameter int DATA_W       = 32,
    parameter int STD60_LINES  = 525,
    parameter int STD60_NS     = 31746,
    parameter int STD50_LINES  = 625,
    parameter int STD50_NS     = 32000,
    parameter int PRESENT_LINE = 65
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NS_W-1:0]    ns_elapsed,
    input  logic               std_50hz,
    input  logic               pos_wr_en,
    input  logic [DATA_W-1:0]  pos_wr_data,
    input  logic               base_wr_en,
    output logic [LINE_W-1:0]  line_idx,
    output logic               retrace_pulse,
    output logic               line1_irq,
    output logic               line2_irq,
    output logic               present_pulse,
    output logic [FRAME_W-1:0] frame_count
);
    localparam int MAX_NS = (STD50_NS > STD60_NS) ? STD50_NS : STD60_NS;
    localparam int ACC_W  = $clog2(MAX_NS + (1 << NS_W));

    logic [ACC_W-1:0]        period;
    logic [LINE_W-1:0]       total;
    logic                    advance;
    logic [1:0][LINE_W-1:0]  pos_w;
    vlt_events_t             ev;

    always_comb begin
        period = std_50hz ? ACC_W'(STD50_NS) : ACC_W'(STD60_NS);
        total  = std_50hz ? LINE_W'(STD50_LINES) : LINE_W'(STD60_LINES);
    end

    vlt_accum #(.NS_W(NS_W), .ACC_W(ACC_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .ns_inc(ns_elapsed),
        .period(period), .advance(advance)
    );

    vlt_posreg #(.LINE_W(LINE_W), .DATA_W(DATA_W), .LSB_P1(16), .LSB_P2(0)) u_pos (
        .clk(clk), .rst_n(rst_n), .wr_en(pos_wr_en),
        .wr_data(pos_wr_data), .pos(pos_w)
    );

    vlt_scan #(.LINE_W(LINE_W), .FRAME_W(FRAME_W), .PRESENT_LINE(PRESENT_LINE)) u_scan (
        .clk(clk), .rst_n(rst_n), .advance(advance), .total(total),
        .pos(pos_w), .base_wr(base_wr_en), .line(line_idx),
        .events(ev), .frame_count(frame_count)
    );

    assign retrace_pulse = ev.retrace;
    assign line1_irq     = ev.irq1;
    assign line2_irq     = ev.irq2;
    assign present_pulse = ev.present;
endmodule

// File: rtl/vlt_line_timer_chk.sv
module vlt_line_timer_chk #(
    parameter int LINE_W  = 10,
    parameter int FRAME_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [LINE_W-1:0]      line_idx,
    input logic                   retrace_pulse,
    input logic                   line1_irq,
    input logic                   line2_irq,
    input logic                   present_pulse,
    input logic [FRAME_W-1:0]     frame_count,
    input logic [1:0][LINE_W-1:0] pos
);
    assert_line_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_idx != $past(line_idx)) |->
            (line_idx == LINE_W'($past(line_idx) + 1'b1) || line_idx == '0));

    assert_retrace_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        retrace_pulse |-> (line_idx == '0));

    assert_irq1_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line1_irq |-> (line_idx == $past(pos[1])));

    assert_irq2_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line2_irq |-> (line_idx == $past(pos[0])));

    assert_single_present_R7: assert property (@(posedge clk) disable iff (!rst_n)
        present_pulse |=> !present_pulse);

    assert_frame_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        present_pulse |-> (frame_count == $past(frame_count) + 1'b1));

    assert_frame_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !present_pulse |-> $stable(frame_count));
endmodule

bind vlt_line_timer vlt_line_timer_chk #(.LINE_W(LINE_W), .FRAME_W(FRAME_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_idx(line_idx),
    .retrace_pulse(retrace_pulse), .line1_irq(line1_irq), .line2_irq(line2_irq),
    .present_pulse(present_pulse), .frame_count(frame_count), .pos(pos_w)
);

// File: tb/test_vlt_line_timer.sv
module test_vlt_line_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ns_elapsed = '0;
    logic        std_50hz = 1'b0;
    logic        pos_wr_en = 1'b0;
    logic [31:0] pos_wr_data = '0;
    logic        base_wr_en = 1'b0;
    logic [9:0]  line_idx;
    logic        retrace_pulse, line1_irq, line2_irq, present_pulse;
    logic [31:0] frame_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vlt_line_timer i_vlt_line_timer (
        .clk(clk), .rst_n(rst_n), .ns_elapsed(ns_elapsed), .std_50hz(std_50hz),
        .pos_wr_en(pos_wr_en), .pos_wr_data(pos_wr_data), .base_wr_en(base_wr_en),
        .line_idx(line_idx), .retrace_pulse(retrace_pulse), .line1_irq(line1_irq),
        .line2_irq(line2_irq), .present_pulse(present_pulse), .frame_count(frame_count)
    );

    // accumulator vectors from reset, 60 Hz: increment, cycles, expected line
    localparam int NV = 6;
    localparam int V_NS   [NV] = '{0,   255, 126, 200, 146, 255};
    localparam int V_CYC  [NV] = '{50,  124, 1,   158, 1,   249};
    localparam int V_LINE [NV] = '{0,   0,   1,   1,   2,   4};

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit pal);
        @(negedge clk);
        rst_n = 1'b0; ns_elapsed = '0; base_wr_en = 1'b0; pos_wr_en = 1'b0;
        std_50hz = pal;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 line during reset", line_idx, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 line", line_idx, 0);
        check("R1 frame_count", frame_count, 0);
        check("R1 pulses", {retrace_pulse, line1_irq, line2_irq, present_pulse}, 0);
    endtask

    // free run at 255 ns per clock, checked every cycle against closed form
    task automatic run_free(input int ncyc, input int total, input int per,
                            input int p1, input int p2, input int late_line);
        longint lt, plt;
        int     n, el, fexp;
        bit     pend, ch, base, b1, b2;
        bit     e_ret, e_i1, e_i2, e_pr;
        n = 0; plt = 0; pend = 0; fexp = 0; b1 = 0; b2 = 0;
        ns_elapsed = 8'd255;
        for (int i = 0; i < ncyc; i++) begin
            base = 0;
            if (!b1 && plt / total == 0 && plt % total == 5) begin base = 1; b1 = 1; end
            if (!b2 && plt / total == 1 && plt % total == late_line) begin base = 1; b2 = 1; end
            base_wr_en = base;
            @(posedge clk);
            n++;
            lt = (longint'(255) * n) / per;
            ch = (lt != plt);
            el = int'(lt % total);
            e_ret = ch && el == 0;
            if (e_ret) pend = 1;
            e_i1 = ch && el == p1;
            e_i2 = ch && el == p2;
            e_pr = 0;
            if (ch && el == 65 && pend) begin e_pr = 1; pend = 0; end
            if (base && pend) begin e_pr = 1; pend = 0; end
            fexp += int'(e_pr);
            plt = lt;
            @(negedge clk);
            check("R2/R3 line_idx", line_idx, el);
            check("R4 retrace_pulse", retrace_pulse, e_ret);
            check("R5/R6 line1_irq", line1_irq, e_i1);
            check("R5/R6 line2_irq", line2_irq, e_i2);
            check("R7/R8 present_pulse", present_pulse, e_pr);
            check("R9 frame_count", frame_count, fexp);
        end
        base_wr_en = 1'b0;
        ns_elapsed = '0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R2 remainder vectors
        do_reset(1'b0);
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            ns_elapsed = V_NS[v][7:0];
            repeat (V_CYC[v]) @(posedge clk);
            @(negedge clk);
            ns_elapsed = '0;
            check("R2 accumulator vector", line_idx, V_LINE[v]);
            @(negedge clk);
            check("R2 zero increment holds", line_idx, V_LINE[v]);
        end

        // 60 Hz: R6 position write with stray bits, full frame, present at 65,
        // base write with flag clear (line 5 and line 70) ignored (R8)
        do_reset(1'b0);
        pos_wr_data = 32'hFD23_FC45;   // pos1 = 0x123 = 291, pos2 = 0x045 = 69
        pos_wr_en = 1'b1;
        @(negedge clk);
        pos_wr_en = 1'b0;
        check("R6 write leaves line", line_idx, 0);
        run_free(74200, 525, 31746, 291, 69, 70);

        // 50 Hz: reset positions 0 fire at wrap (R1/R5), base write armed (R8)
        do_reset(1'b1);
        run_free(78900, 625, 32000, 0, 0, 3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule